// File: doc/BRIEF.md
# Four-Entry Voxel-Cell Buffer

This block is the first-level buffer of a ray engine. It keeps the last fetched 2x2x2 voxel cell as four 32-bit data elements, each covering one (Z,Y) low-bit pair of the cell. For every raypoint the engine presents the cell address (coordinates with the low X, Y and Z bits dropped) and a two-bit selector made of the low Z and Y bits. If the cell is resident, the selected element is returned in the same cycle.

On a miss the buffer raises a fetch request that names the cell and the element the raypoint needs. The lower level delivers the four elements, needed element first. That first element goes to the engine in the cycle it arrives, so the engine does not wait for the whole cell. A flush drops the resident cell, for example when a new ray starts.

Top module: `vcell_buf`

## Requirements
- R1: After reset `hit_o`, `rsp_valid_o` and `fetch_req_o` are 0, and no lookup hits until a fill has completed.
- R2: In the idle state, a lookup (`req_valid_i`=1) whose `req_cell_i` equals the resident valid cell gives `hit_o`=1 and `rsp_valid_o`=1 in the same cycle, with `rsp_data_o` = entry `req_sel_i`, where selector bit 1 is the low Z bit and bit 0 the low Y bit (index = 2*z0 + y0).
- R3: An idle lookup that misses gives `hit_o`=0. From the next cycle `fetch_req_o` is 1, with `fetch_cell_o` = the missed cell and `fetch_first_o` = its selector. It stays 1 up to and including the cycle where `fill_valid_i` is first 1, and is 0 after it.
- R4: The first fill word is written to entry `fetch_first_o`. In that same cycle `rsp_valid_o`=1 and `rsp_data_o` = `fill_data_i`.
- R5: The next three fill words, which may have gaps, go to entries (first+1) mod 4, (first+2) mod 4 and (first+3) mod 4, in that order.
- R6: From the cycle after the fourth fill word, the filled cell is valid, and all four selectors of it hit with the stored words.
- R7: From the miss until the fourth fill word, lookups are ignored: `hit_o` is 0, no response except the forwarded first word, and no new fetch.
- R8: `flush_i` invalidates the resident cell from the next cycle on. A flush during a fill lets the fill take its four words, but the cell is not valid afterwards.
- R9: `fill_valid_i` in the idle state is ignored and leaves the stored words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Invalidate the resident cell |
| req_valid_i | input | 1 | Lookup strobe |
| req_cell_i | input | CELL_W | Cell address of the raypoint |
| req_sel_i | input | 2 | {low Z bit, low Y bit} of the raypoint |
| hit_o | output | 1 | Lookup hit the resident cell |
| rsp_valid_o | output | 1 | `rsp_data_o` carries the requested element |
| rsp_data_o | output | DATA_W | Requested element |
| fetch_req_o | output | 1 | Fetch of a cell pending |
| fetch_cell_o | output | CELL_W | Cell to fetch |
| fetch_first_o | output | 2 | Element index to deliver first |
| fill_valid_i | input | 1 | Fill word strobe |
| fill_data_i | input | DATA_W | Fill word |

## Verification
The bench goes after the wrap of the fill order when the needed element is index 2 or 3. A design that filled in plain 0..3 order would then return the wrong words on later hits. It also checks forwarding of the first word while the fetch is still pending. A design that held the response until the fill completed would show no response in that cycle. It also covers lookups arriving mid-fill, which must neither hit stale data nor start a second fetch, and stray fill strobes in the idle state, which would silently corrupt the stored words. Flushes are placed before, during and on the last word of a fill, where a wrongly ordered valid update would leave a flushed cell hitting.

// File: rtl/vcb_pkg.sv
// Shared types and sizes for the voxel-cell buffer.
package vcb_pkg;
    localparam int SEL_W       = 2;
    localparam int NUM_ENTRIES = 1 << SEL_W;

    // Fill sequencer states: idle, waiting for the first word, taking the remaining words
    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_WAIT = 2'd1,
        FS_FILL = 2'd2
    } fill_state_t;
endpackage

// File: rtl/vcb_tag.sv
// Tag register of the voxel-cell buffer.
// Holds the address of the resident cell and its valid bit, and compares it with the lookup.
// Assumes load, clear and set never request contradictory updates in the same cycle,
// except that clear and load both drop the valid bit.
module vcb_tag #(
    parameter int CELL_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CELL_W-1:0] load_cell_i,
    input  logic              clr_i,
    input  logic              set_i,
    input  logic [CELL_W-1:0] cmp_cell_i,
    output logic              match_o,
    output logic [CELL_W-1:0] cell_o
);
    logic              valid_q;
    logic [CELL_W-1:0] cell_q;

    // Capture the missed cell on load; the valid bit follows clear, load and set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            cell_q  <= '0;
        end else begin
            if (load_i) begin
                cell_q <= load_cell_i;
            end
            if (clr_i || load_i) begin
                valid_q <= 1'b0;
            end else if (set_i) begin
                valid_q <= 1'b1;
            end
        end
    end

    // Resident-cell comparison
    always_comb begin
        match_o = valid_q && (cell_q == cmp_cell_i);
        cell_o  = cell_q;
    end
endmodule

// File: rtl/vcb_store.sv
// Element storage of the voxel-cell buffer: NUM_ENTRIES words with one write and one read port.
// Assumes at most one write per cycle; reads are combinational.
module vcb_store
    import vcb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [SEL_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [SEL_W-1:0]  rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o
);
    logic [DATA_W-1:0] words_q [NUM_ENTRIES];

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
        // Write entry g when the write index selects it
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words_q[g] <= '0;
            end else if (wr_en_i && (wr_idx_i == SEL_W'(g))) begin
                words_q[g] <= wr_data_i;
            end
        end
    end

    // Read mux
    always_comb begin
        rd_data_o = words_q[rd_idx_i];
    end
endmodule

// File: rtl/vcb_fill_ctrl.sv
// Fill sequencer of the voxel-cell buffer.
// Starts on a miss, waits for the first word, then writes the words to first, first+1,
// first+2 and first+3 (mod 4). Marks the cell valid at the end unless a flush was seen.
// Assumes the lower level delivers exactly four words per request.
module vcb_fill_ctrl
    import vcb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_i,
    input  logic [SEL_W-1:0] miss_sel_i,
    input  logic             flush_i,
    input  logic             fill_valid_i,
    output logic             idle_o,
    output logic             waiting_o,
    output logic             wr_en_o,
    output logic [SEL_W-1:0] wr_idx_o,
    output logic             tag_set_o,
    output logic [SEL_W-1:0] first_o
);
    fill_state_t      state_q;
    logic [SEL_W-1:0] first_q;
    logic [SEL_W-1:0] cnt_q;
    logic             drop_q;

    // Sequencer state, first index, word counter and flush-during-fill flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
            first_q <= '0;
            cnt_q   <= '0;
            drop_q  <= 1'b0;
        end else begin
            case (state_q)
                FS_IDLE: begin
                    if (miss_i) begin
                        state_q <= FS_WAIT;
                        first_q <= miss_sel_i;
                        cnt_q   <= '0;
                        drop_q  <= 1'b0;
                    end
                end
                FS_WAIT: begin
                    if (flush_i) begin
                        drop_q <= 1'b1;
                    end
                    if (fill_valid_i) begin
                        state_q <= FS_FILL;
                        cnt_q   <= cnt_q + 1'b1;
                    end
                end
                FS_FILL: begin
                    if (flush_i) begin
                        drop_q <= 1'b1;
                    end
                    if (fill_valid_i) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == SEL_W'(NUM_ENTRIES - 1)) begin
                            state_q <= FS_IDLE;
                        end
                    end
                end
                default: state_q <= FS_IDLE;
            endcase
        end
    end

    // Write strobe, wrapping write index and completion
    always_comb begin
        idle_o    = (state_q == FS_IDLE);
        waiting_o = (state_q == FS_WAIT);
        wr_en_o   = fill_valid_i && !idle_o;
        wr_idx_o  = first_q + cnt_q;
        tag_set_o = fill_valid_i && (state_q == FS_FILL)
                    && (cnt_q == SEL_W'(NUM_ENTRIES - 1)) && !drop_q && !flush_i;
        first_o   = first_q;
    end
endmodule

// File: rtl/vcell_buf.sv
// Four-entry voxel-cell buffer: keeps one 2x2x2 cell as four elements indexed by {z0,y0}.
// Hits are answered combinationally. A miss starts a fetch whose first word is forwarded.
// Assumes the requester waits for rsp_valid_o after a miss and presents its lookup again
// once the fill is done if it needs other elements.
module vcell_buf
    import vcb_pkg::*;
#(
    parameter int CELL_W = 21,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              req_valid_i,
    input  logic [CELL_W-1:0] req_cell_i,
    input  logic [SEL_W-1:0]  req_sel_i,
    output logic              hit_o,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_data_o,
    output logic              fetch_req_o,
    output logic [CELL_W-1:0] fetch_cell_o,
    output logic [SEL_W-1:0]  fetch_first_o,
    input  logic              fill_valid_i,
    input  logic [DATA_W-1:0] fill_data_i
);
    logic              match;
    logic              idle;
    logic              waiting;
    logic              miss;
    logic              wr_en;
    logic [SEL_W-1:0]  wr_idx;
    logic              tag_set;
    logic [DATA_W-1:0] rd_data;

    // Lookup decisions: only the idle state answers or starts fetches
    always_comb begin
        hit_o = req_valid_i && idle && match;
        miss  = req_valid_i && idle && !match;
    end

    vcb_tag #(.CELL_W(CELL_W)) u_tag (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (miss),
        .load_cell_i(req_cell_i),
        .clr_i      (flush_i),
        .set_i      (tag_set),
        .cmp_cell_i (req_cell_i),
        .match_o    (match),
        .cell_o     (fetch_cell_o)
    );

    vcb_fill_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .miss_i      (miss),
        .miss_sel_i  (req_sel_i),
        .flush_i     (flush_i),
        .fill_valid_i(fill_valid_i),
        .idle_o      (idle),
        .waiting_o   (waiting),
        .wr_en_o     (wr_en),
        .wr_idx_o    (wr_idx),
        .tag_set_o   (tag_set),
        .first_o     (fetch_first_o)
    );

    vcb_store #(.DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en),
        .wr_idx_i (wr_idx),
        .wr_data_i(fill_data_i),
        .rd_idx_i (req_sel_i),
        .rd_data_o(rd_data)
    );

    // Response: stored element on a hit, the arriving word when it is the needed one
    always_comb begin
        fetch_req_o = waiting;
        rsp_valid_o = hit_o || (waiting && fill_valid_i);
        rsp_data_o  = waiting ? fill_data_i : rd_data;
    end
endmodule

// File: rtl/vcb_checks.sv
// Protocol checks for the voxel-cell buffer, bound to every vcell_buf instance.
module vcb_checks #(
    parameter int CELL_W = 21,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush_i,
    input logic              req_valid_i,
    input logic              hit_o,
    input logic              rsp_valid_o,
    input logic [DATA_W-1:0] rsp_data_o,
    input logic              fetch_req_o,
    input logic              fill_valid_i,
    input logic [DATA_W-1:0] fill_data_i
);
    assert_hit_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> rsp_valid_o);

    assert_rsp_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> (hit_o || (fetch_req_o && fill_valid_i)));

    assert_fetch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req_o && !fill_valid_i) |=> fetch_req_o);

    assert_fetch_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req_o && fill_valid_i) |=> !fetch_req_o);

    assert_fetch_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fetch_req_o) |-> $past(req_valid_i && !hit_o));

    assert_forward_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req_o && fill_valid_i) |-> (rsp_valid_o && rsp_data_o == fill_data_i));

    assert_no_hit_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req_o |-> !hit_o);

    assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !hit_o);
endmodule

bind vcell_buf vcb_checks #(.CELL_W(CELL_W), .DATA_W(DATA_W)) u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_i     (flush_i),
    .req_valid_i (req_valid_i),
    .hit_o       (hit_o),
    .rsp_valid_o (rsp_valid_o),
    .rsp_data_o  (rsp_data_o),
    .fetch_req_o (fetch_req_o),
    .fill_valid_i(fill_valid_i),
    .fill_data_i (fill_data_i)
);

// File: tb/tb_vcell_buf.sv
module tb_vcell_buf;
    localparam int CW = 21;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush_i = 1'b0;
    logic          req_valid_i = 1'b0;
    logic [CW-1:0] req_cell_i = '0;
    logic [1:0]    req_sel_i = '0;
    logic          fill_valid_i = 1'b0;
    logic [DW-1:0] fill_data_i = '0;
    logic          hit_o, rsp_valid_o, fetch_req_o;
    logic [DW-1:0] rsp_data_o;
    logic [CW-1:0] fetch_cell_o;
    logic [1:0]    fetch_first_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    vcell_buf #(.CELL_W(CW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
        .req_valid_i(req_valid_i), .req_cell_i(req_cell_i), .req_sel_i(req_sel_i),
        .hit_o(hit_o), .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o),
        .fetch_req_o(fetch_req_o), .fetch_cell_o(fetch_cell_o), .fetch_first_o(fetch_first_o),
        .fill_valid_i(fill_valid_i), .fill_data_i(fill_data_i)
    );

    // Reference state from the requirements: 0 idle, 1 waiting for first word, 2 filling
    int            m_mode = 0;
    bit            m_valid = 1'b0;
    logic [CW-1:0] m_cell = '0;
    logic [CW-1:0] m_pcell = '0;
    logic [1:0]    m_first = '0;
    logic [1:0]    m_cnt = '0;
    bit            m_drop = 1'b0;
    logic [DW-1:0] m_mem [4];

    function automatic bit exp_hit(bit rv, logic [CW-1:0] c);
        return (m_mode == 0) && rv && m_valid && (c == m_cell);
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One cycle: drive inputs, compare every output with the reference, advance the reference
    task automatic step(bit rv, logic [CW-1:0] c, logic [1:0] s, bit fv,
                        logic [DW-1:0] fd, bit fl, string tag);
        bit eh, erv, efr;
        logic [DW-1:0] ed;
        @(negedge clk);
        req_valid_i = rv; req_cell_i = c; req_sel_i = s;
        fill_valid_i = fv; fill_data_i = fd; flush_i = fl;
        #2;
        eh  = exp_hit(rv, c);
        efr = (m_mode == 1);
        erv = eh || (efr && fv);
        ed  = efr ? fd : m_mem[s];
        chk(hit_o == eh, {tag, " hit"}, 64'(hit_o), 64'(eh));
        chk(rsp_valid_o == erv, {tag, " rsp_valid"}, 64'(rsp_valid_o), 64'(erv));
        if (erv) chk(rsp_data_o == ed, {tag, " rsp_data"}, 64'(rsp_data_o), 64'(ed));
        chk(fetch_req_o == efr, {tag, " fetch_req"}, 64'(fetch_req_o), 64'(efr));
        if (efr) begin
            chk(fetch_cell_o == m_pcell, {tag, " fetch_cell"}, 64'(fetch_cell_o), 64'(m_pcell));
            chk(fetch_first_o == m_first, {tag, " fetch_first"}, 64'(fetch_first_o), 64'(m_first));
        end
        case (m_mode)
            0: begin
                if (fl) m_valid = 1'b0;
                if (rv && !eh) begin
                    m_mode = 1; m_pcell = c; m_first = s; m_valid = 1'b0; m_drop = 1'b0;
                end
            end
            1: begin
                if (fl) m_drop = 1'b1;
                if (fv) begin
                    m_mem[m_first] = fd; m_cnt = 2'd1; m_mode = 2;
                end
            end
            default: begin
                if (fl) m_drop = 1'b1;
                if (fv) begin
                    m_mem[m_first + m_cnt] = fd;
                    if (m_cnt == 2'd3) begin
                        m_mode = 0; m_cell = m_pcell; m_valid = !m_drop;
                    end
                    m_cnt = m_cnt + 2'd1;
                end
            end
        endcase
    endtask

    function automatic logic [DW-1:0] word_of(logic [CW-1:0] c, int k);
        return {c[7:0], 8'hA5, 8'(k), 8'h3C};
    endfunction

    // Miss on cell c with selector s, then deliver the four words in fill order
    task automatic miss_and_fill(logic [CW-1:0] c, logic [1:0] s, bit fl_mid, string tag);
        step(1, c, s, 0, '0, 0, tag);
        step(1, c, s, 0, '0, 0, tag);
        for (int k = 0; k < 4; k++) begin
            step(1, c, s, 1, word_of(c, k), fl_mid && (k == 2), tag);
            if (k == 1) step(1, c, s, 0, '0, 0, "R7");
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [CW-1:0] pool [4];
        void'($urandom(32'd1234));
        for (int i = 0; i < 4; i++) m_mem[i] = '0;
        pool[0] = 21'h00155; pool[1] = 21'h1F0F0; pool[2] = 21'h00156; pool[3] = 21'h0ABCD;
        repeat (3) @(negedge clk);
        #2;
        chk(!hit_o && !rsp_valid_o && !fetch_req_o, "R1 reset outputs",
            64'({hit_o, rsp_valid_o, fetch_req_o}), 64'(0));
        @(negedge clk); rst_n = 1'b1;
        // R1: first lookup after reset misses even for cell 0
        step(1, '0, 2'd0, 0, '0, 0, "R1");
        step(0, '0, 2'd0, 1, 32'h11, 0, "R4");
        step(0, '0, 2'd0, 1, 32'h22, 0, "R5");
        step(0, '0, 2'd0, 1, 32'h33, 0, "R5");
        step(0, '0, 2'd0, 1, 32'h44, 0, "R5");
        for (int s = 0; s < 4; s++) step(1, '0, 2'(s), 0, '0, 0, "R6");
        // R5: wrapping fill orders with first index 2 and 3
        miss_and_fill(pool[0], 2'd2, 0, "R3");
        for (int s = 0; s < 4; s++) begin
            step(1, pool[0], 2'(s), 0, '0, 0, "R5");
            chk(rsp_data_o == word_of(pool[0], (s - 2 + 4) % 4), "R5 order",
                64'(rsp_data_o), 64'(word_of(pool[0], (s - 2 + 4) % 4)));
        end
        miss_and_fill(pool[1], 2'd3, 0, "R4");
        for (int s = 0; s < 4; s++) step(1, pool[1], 2'(s), 0, '0, 0, "R6");
        // R9: stray fill strobes while idle leave data unchanged
        step(0, '0, 2'd0, 1, 32'hDEAD_BEEF, 0, "R9");
        step(1, pool[1], 2'd3, 0, '0, 0, "R9");
        chk(rsp_data_o == word_of(pool[1], 0), "R9 data kept",
            64'(rsp_data_o), 64'(word_of(pool[1], 0)));
        // R8: flush in idle, then lookup misses
        step(0, '0, 2'd0, 0, '0, 1, "R8");
        step(1, pool[1], 2'd1, 0, '0, 0, "R8");
        chk(!hit_o && !rsp_valid_o, "R8 miss after flush", 64'(hit_o), 64'(0));
        step(0, '0, 2'd0, 1, 32'h5, 0, "R8");
        step(0, '0, 2'd0, 1, 32'h6, 0, "R8");
        step(0, '0, 2'd0, 1, 32'h7, 0, "R8");
        step(0, '0, 2'd0, 1, 32'h8, 1, "R8");
        step(1, pool[1], 2'd1, 0, '0, 0, "R8");
        chk(!hit_o, "R8 flush on last word", 64'(hit_o), 64'(0));
        // R8: flush mid-fill drops the cell; R7 lookups mid-fill are ignored
        step(0, '0, 2'd0, 1, 32'h9, 0, "R7");
        step(1, pool[1], 2'd1, 1, 32'hA, 0, "R7");
        step(1, pool[2], 2'd2, 1, 32'hB, 0, "R7");
        step(1, pool[1], 2'd1, 1, 32'hC, 0, "R7");
        miss_and_fill(pool[2], 2'd1, 1, "R8");
        step(1, pool[2], 2'd1, 0, '0, 0, "R8");
        chk(!hit_o && fetch_req_o == 1'b0, "R8 dropped cell", 64'(hit_o), 64'(0));
        // Random phase: R2 R3 R4 R5 R7 R8 R9 under mixed traffic
        for (int n = 0; n < 4000; n++) begin
            bit rv, fv, fl;
            rv = ($urandom % 10) < 7;
            fl = ($urandom % 40) == 0;
            fv = (m_mode == 0) ? (($urandom % 10) == 0) : (($urandom % 10) < 5);
            step(rv, pool[$urandom % 4], 2'($urandom), fv, $urandom, fl, "R2/R3 random");
        end
        // Drain any fill in progress
        while (m_mode != 0) step(0, '0, 2'd0, 1, $urandom, 0, "R5 drain");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule